// File: doc/BRIEF.md
# Configurable Edge Event Counter

This block counts edges on an asynchronous data-condition input. The input is brought into the system clock domain through a short flip-flop chain. A single-cycle event is produced for each qualifying edge, and either the rising or the falling edge can be chosen as the qualifying one. An 8-bit counter then steps on each event: it counts up, counts down toward zero, or holds, as a control word selects.

The counter can be preset from a parallel load port at any time. A control bit can make the counter freeze at zero once a count step brings it there. A compare-equal pulse marks the cycle in which a step lands on zero. A single output pin carries one of four signals chosen by a control field: a constant low, the compare-equal pulse, the synchronised input level, or the frozen-at-zero flag.

Top module: `evt_edge_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0, the frozen-at-zero flag clears and `dco` goes to 0 in every output selection.
- R2: `load_en` high at a rising edge writes `load_val` into `count` at that edge. It overrides any event in the same cycle and clears the frozen-at-zero flag.
- R3: With `ctrl[4]`=0, each rising edge of `dci` moves the count by one step. The step takes effect at the third rising clock edge after `dci` is first sampled high. A falling edge of `dci` has no effect.
- R4: With `ctrl[4]`=1, each falling edge of `dci` moves the count by one step with the same latency, and a rising edge has no effect.
- R5: The count mode is `ctrl[1:0]`: 01 counts up, 10 counts down, and both 00 and 11 hold the count unchanged on events.
- R6: In up mode with latching off, a step from 255 wraps the count to 0.
- R7: In down mode with latching off, an event at count 0 leaves the count at 0; it never wraps to 255.
- R8: With `ctrl[11]`=1, a count step that reaches 0 sets a frozen-at-zero flag. While the flag is set the count stays 0 on every event, in any mode, until a load or reset.
- R9: A compare-equal pulse is high for exactly one clock cycle, the cycle after a count step changes the count from a nonzero value to 0. An event at count 0 and a load to 0 give no pulse.
- R10: `ctrl[9:8]` selects `dco`: 00 drives 0, 01 the compare-equal pulse, 10 the synchronised `dci` level (high two clock edges after `dci` is sampled high), and 11 the frozen-at-zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dci | input | 1 | Asynchronous data-condition input being counted |
| ctrl | input | 12 | Control word: mode [1:0], edge select [4], output select [9:8], zero latch [11] |
| load_en | input | 1 | Load strobe for the counter |
| load_val | input | 8 | Value written to the counter on a load |
| count | output | 8 | Current counter value |
| dco | output | 1 | Selected status output |

## Verification
The input is toggled under both edge selections, so that a counter stepping on the wrong polarity, or on both polarities, shows as an off-by-one count. Runs of events in each of the four mode codes separate the up, down and hold decodes. Sequences from 254 upward and from 1 downward reach the wrap and saturate boundaries, and show whether the compare pulse follows a real step to zero or mere equality with zero. Repeating these sequences with the zero latch enabled, then switching mode and reloading, shows whether the freeze holds and whether a load releases it. An event that arrives while the load strobe is held checks load priority.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int CTRL_W    = 12;
    localparam int MODE_LSB  = 0;
    localparam int EDGE_BIT  = 4;
    localparam int OSEL_LSB  = 8;
    localparam int LATCH_BIT = 11;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_UP    = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_HOLDX = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        OSEL_OFF   = 2'b00,
        OSEL_CE    = 2'b01,
        OSEL_LEVEL = 2'b10,
        OSEL_HELD  = 2'b11
    } osel_e;

    typedef struct packed {
        logic      latch_en;
        osel_e     osel;
        logic      neg_edge;
        cnt_mode_e mode;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.mode     = cnt_mode_e'(w[MODE_LSB +: 2]);
        c.neg_edge = w[EDGE_BIT];
        c.osel     = osel_e'(w[OSEL_LSB +: 2]);
        c.latch_en = w[LATCH_BIT];
        return c;
    endfunction

endpackage

// File: rtl/evtc_sync_edge.sv
module evtc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic neg_edge,
    output logic level,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign evt   = neg_edge ? (~level & prev) : (level & ~prev);

endmodule

// File: rtl/evtc_count_core.sv
module evtc_count_core
    import evtc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  cnt_mode_e        mode,
    input  logic             latch_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             held,
    output logic             ce
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] nxt;
    logic             step;
    logic             lands_zero;

    always_comb begin
        nxt  = count;
        step = 1'b0;
        if (evt && !held) begin
            unique case (mode)
                MODE_UP: begin
                    nxt  = count + ONE;
                    step = 1'b1;
                end
                MODE_DOWN: begin
                    if (count != ZERO) begin
                        nxt  = count - ONE;
                        step = 1'b1;
                    end
                end
                default: begin
                    nxt  = count;
                    step = 1'b0;
                end
            endcase
        end
    end

    assign lands_zero = step && (nxt == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
            held  <= 1'b0;
            ce    <= 1'b0;
        end else if (load_en) begin
            count <= load_val;
            held  <= 1'b0;
            ce    <= 1'b0;
        end else begin
            count <= nxt;
            ce    <= lands_zero;
            if (lands_zero && latch_en) held <= 1'b1;
        end
    end

endmodule

// File: rtl/evtc_out_mux.sv
module evtc_out_mux
    import evtc_pkg::*;
(
    input  osel_e osel,
    input  logic  ce,
    input  logic  level,
    input  logic  held,
    output logic  dout
);
    always_comb begin
        unique case (osel)
            OSEL_CE:    dout = ce;
            OSEL_LEVEL: dout = level;
            OSEL_HELD:  dout = held;
            default:    dout = 1'b0;
        endcase
    end
endmodule

// File: rtl/evt_edge_counter.sv
module evt_edge_counter
    import evtc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dci,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count,
    output logic              dco
);
    ctrl_t cfg;
    logic  level_w;
    logic  evt_w;
    logic  held_w;
    logic  ce_w;

    assign cfg = decode_ctrl(ctrl);

    evtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (dci),
        .neg_edge (cfg.neg_edge),
        .level    (level_w),
        .evt      (evt_w)
    );

    evtc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .mode     (cfg.mode),
        .latch_en (cfg.latch_en),
        .load_en  (load_en),
        .load_val (load_val),
        .count    (count),
        .held     (held_w),
        .ce       (ce_w)
    );

    evtc_out_mux u_mux (
        .osel  (cfg.osel),
        .ce    (ce_w),
        .level (level_w),
        .held  (held_w),
        .dout  (dco)
    );

endmodule

// File: rtl/evtc_checker.sv
module evtc_checker
    import evtc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [CTRL_W-1:0] ctrl,
    input logic              load_en,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  count,
    input logic              dco,
    input logic              held
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count == '0) && !dco && !held);

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_val)) && !held);

    assert_hold_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_en && (ctrl[1:0] == 2'b00 || ctrl[1:0] == 2'b11)) |=> $stable(count));

    assert_down_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && ctrl[1:0] == 2'b10 && count == '0) |=> count == '0);

    assert_frozen_zero_R8: assert property (@(posedge clk) disable iff (rst)
        held |-> count == '0);

    assert_frozen_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (held && !load_en) |=> held && count == '0);

    assert_ce_single_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[9:8] == 2'b01 && dco && !load_en) |=> !(dco && $stable(ctrl[9:8])));

    assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl[9:8] == 2'b00) |-> !dco);
endmodule

bind evt_edge_counter evtc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .load_en  (load_en),
    .load_val (load_val),
    .count    (count),
    .dco      (dco),
    .held     (held_w)
);

// File: tb/evt_edge_counter_tb.sv
module evt_edge_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dci = 1'b0;
    logic [11:0] ctrl = '0;
    logic        load_en = 1'b0;
    logic [7:0]  load_val = '0;
    logic [7:0]  count;
    logic        dco;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_edge_counter u_dut (
        .clk(clk), .rst(rst), .dci(dci), .ctrl(ctrl),
        .load_en(load_en), .load_val(load_val),
        .count(count), .dco(dco)
    );

    // mode: 0 hold,1 up,2 down; osel: 0 off,1 ce,2 level,3 frozen flag
    function automatic logic [11:0] mk(input int mode, input bit neg,
                                       input int osel, input bit latch);
        logic [11:0] w = '0;
        w[1:0] = mode[1:0];
        w[4]   = neg;
        w[9:8] = osel[1:0];
        w[11]  = latch;
        return w;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // change dci; returns at the sample point where the resulting step is visible
    task automatic dci_set(input logic v);
        @(negedge clk);
        dci = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", count, 0, "count after reset");
        chk("R1", dco, 0, "dco after reset");
    endtask

    task automatic t_edges;
        ctrl = mk(1, 0, 0, 0);
        load(8'd5);
        chk("R2", count, 5, "loaded value");
        dci_set(1); chk("R3", count, 6, "rising edge counts");
        dci_set(0); chk("R3", count, 6, "falling edge ignored");
        ctrl = mk(1, 1, 0, 0);
        dci_set(1); chk("R4", count, 6, "rising ignored in neg mode");
        dci_set(0); chk("R4", count, 7, "falling edge counts");
    endtask

    task automatic t_modes;
        ctrl = mk(0, 0, 0, 0);
        dci_set(1); dci_set(0);
        chk("R5", count, 7, "mode 00 holds");
        ctrl = mk(3, 0, 0, 0);
        dci_set(1); dci_set(0);
        chk("R5", count, 7, "mode 11 holds");
        ctrl = mk(2, 0, 0, 0);
        dci_set(1); dci_set(0);
        chk("R5", count, 6, "mode 10 counts down");
    endtask

    task automatic t_wrap;
        ctrl = mk(1, 0, 1, 0);
        load(8'd254);
        dci_set(1); chk("R6", count, 255, "step to 255");
        dci_set(0);
        dci_set(1); chk("R6", count, 0, "wrap to 0");
        chk("R9", dco, 1, "ce on wrap");
        @(negedge clk); chk("R9", dco, 0, "ce one cycle");
        dci_set(0);
    endtask

    task automatic t_down_sat;
        ctrl = mk(2, 0, 1, 0);
        load(8'd0);
        chk("R9", dco, 0, "no ce on load of 0");
        load(8'd1);
        dci_set(1); chk("R9", count, 0, "down to 0");
        chk("R9", dco, 1, "ce on step to 0");
        @(negedge clk); chk("R9", dco, 0, "ce drops");
        dci_set(0);
        dci_set(1); chk("R7", count, 0, "saturate at 0");
        chk("R9", dco, 0, "no ce at 0 event");
        dci_set(0);
    endtask

    task automatic t_latch;
        ctrl = mk(2, 0, 3, 1);
        load(8'd2);
        dci_set(1); chk("R8", count, 1, "down 2->1");
        chk("R10", dco, 0, "flag clear");
        dci_set(0);
        dci_set(1); chk("R8", count, 0, "down to 0");
        chk("R10", dco, 1, "frozen flag on dco");
        dci_set(0);
        ctrl = mk(1, 0, 3, 1);
        dci_set(1); chk("R8", count, 0, "frozen despite up mode");
        dci_set(0);
        load(8'd9);
        chk("R2", count, 9, "load releases");
        chk("R2", dco, 0, "load clears flag");
        dci_set(1); chk("R8", count, 10, "counts after release");
        dci_set(0);
        load(8'd255);
        dci_set(1); chk("R8", count, 0, "up wrap freezes");
        dci_set(0);
        dci_set(1); chk("R8", count, 0, "stays frozen");
        dci_set(0);
    endtask

    task automatic t_load_prio;
        ctrl = mk(1, 0, 0, 0);
        @(negedge clk);
        load_en = 1'b1; load_val = 8'd40;
        dci = 1'b1;
        repeat (4) @(negedge clk);
        load_en = 1'b0;
        chk("R2", count, 40, "load beats event");
        repeat (2) @(negedge clk);
        chk("R2", count, 40, "no late step");
        dci_set(0);
    endtask

    task automatic t_outsel;
        ctrl = mk(2, 0, 0, 0);
        load(8'd1);
        dci_set(1); chk("R10", count, 0, "step to 0");
        chk("R10", dco, 0, "sel 00 masks ce");
        dci_set(0);
        ctrl = mk(0, 0, 2, 0);
        @(negedge clk); dci = 1'b1;
        @(negedge clk); chk("R10", dco, 0, "level not yet");
        @(negedge clk); chk("R10", dco, 1, "level after two edges");
        dci = 1'b0;
        repeat (2) @(negedge clk); chk("R10", dco, 0, "level low again");
    endtask

    task automatic t_midreset;
        ctrl = mk(1, 0, 3, 1);
        load(8'd255);
        dci_set(1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", count, 0, "count after mid reset");
        chk("R1", dco, 0, "flag cleared by reset");
        dci_set(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edges();
        t_modes();
        t_wrap();
        t_down_sat();
        t_latch();
        t_load_prio();
        t_outsel();
        t_midreset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule